// File: doc/BRIEF.md
# Interrupt Aggregation and Soft-Reset Front-End

This block sits between a peripheral core and a simple 32-bit register bus. It collects eight single-cycle event pulses from the core into a sticky status register. Software can flip any status bit by writing it. A per-source enable register and one master enable bit decide whether the collected events reach a single interrupt line.

The same register window also holds a keyed soft-reset trigger. Writing the key value starts a fixed-length reset pulse towards the core, and the status and enable registers stay cleared for that whole window. Any other value written there does nothing. Reads are combinational: `bus_rdata` shows the register selected by `bus_addr` in the same cycle, and reading has no side effects.

Top module: `irq_reset_frontend`

## Requirements
- R1: After `rst_n` is released, every register reads 0, `irq_out` is 0 and `core_rst_out` is 0.
- R2: The master enable is bit 31 of offset 0x1C. A write stores `bus_wdata[31]`. Reads return it in bit 31 and 0 in all other bits.
- R3: The source enable register is at offset 0x28. A write stores `bus_wdata[7:0]`, and reads return those bits with 0 above them.
- R4: Writing offset 0x20 inverts every status bit whose `bus_wdata` bit is 1 and keeps the others. Reads of 0x20 return the status in bits 7:0.
- R5: A pulse on `ev_in[i]` sets status bit i at the next clock edge. The sources are: 0 arbitration lost, 1 transmit error, 2 transmit empty, 3 receive full, 4 bus idle, 5 addressed as target, 6 no longer addressed, 7 transmit half empty.
- R6: When an event and an inverting write hit the same bit in the same cycle, the bit ends up 1.
- R7: `irq_out` is 1 exactly when the master enable is 1 and at least one bit is set in both status and source enable. It follows register changes with no extra delay.
- R8: Writing 0x0000000A to offset 0x40 drives `core_rst_out` high for exactly 16 cycles, starting in the cycle after the write. A key write made while the pulse is running restarts the 16 cycles.
- R9: Writing any value other than 0x0000000A to offset 0x40 leaves `core_rst_out` and all registers unchanged.
- R10: The key write clears status and source enable. While `core_rst_out` is high, both stay 0 and ignore events and writes. The master enable keeps its value and stays writable.
- R11: Offset 0x40 and all unmapped offsets read as 0. Writes to unmapped offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_in | input | 8 | Single-cycle event pulses from the core |
| irq_out | output | 1 | Interrupt request line |
| core_rst_out | output | 1 | Reset pulse to the peripheral core |

## Verification
A wrong status, enable or master-enable bit appears on `bus_rdata` as soon as software reads that offset. It also shows on `irq_out` in the same cycle whenever the bit takes part in the interrupt condition. A fault in the reset counter shows on `core_rst_out` as a pulse that is too short, too long or missing; the mismatch is visible at the first cycle where the pulse edge should have moved. Because the reference model is compared against the read-back register, `irq_out` and `core_rst_out` on every clock, any divergence is flagged in the cycle it first reaches a port.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;
  localparam int unsigned NUM_SRC   = 8;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned GIE_BIT   = 31;
  localparam int unsigned OFS_GIE   = 'h1C;
  localparam int unsigned OFS_STAT  = 'h20;
  localparam int unsigned OFS_EN    = 'h28;
  localparam int unsigned OFS_SRST  = 'h40;
  localparam logic [31:0] SRST_KEY  = 32'h0000_000A;

  // event source positions in the status and enable registers
  localparam int unsigned SRC_ARB_LOST  = 0;
  localparam int unsigned SRC_TX_ERR    = 1;
  localparam int unsigned SRC_TX_EMPTY  = 2;
  localparam int unsigned SRC_RX_FULL   = 3;
  localparam int unsigned SRC_BUS_IDLE  = 4;
  localparam int unsigned SRC_ADDR_HIT  = 5;
  localparam int unsigned SRC_ADDR_MISS = 6;
  localparam int unsigned SRC_TX_HALF   = 7;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GIE,
    SEL_STAT,
    SEL_EN,
    SEL_SRST
  } reg_sel_t;
endpackage

// File: rtl/irqfe_decode.sv
module irqfe_decode
  import irqfe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    if (addr == ADDR_W'(OFS_GIE))       sel = SEL_GIE;
    else if (addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
    else if (addr == ADDR_W'(OFS_EN))   sel = SEL_EN;
    else if (addr == ADDR_W'(OFS_SRST)) sel = SEL_SRST;
    else                                sel = SEL_NONE;
  end
endmodule

// File: rtl/irqfe_status_bits.sv
module irqfe_status_bits #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tgl_en,
  input  logic [N-1:0] tgl,
  input  logic [N-1:0] ev,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic nxt;
    logic upd;

    always_comb begin
      upd = clr | ev[i] | (tgl_en & tgl[i]);
      if (clr)        nxt = 1'b0;
      else if (ev[i]) nxt = 1'b1;    // event beats an inverting write
      else            nxt = ~q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[i] <= 1'b0;
      else if (upd) q[i] <= nxt;
    end
  end
endmodule

// File: rtl/irqfe_rst_timer.sv
module irqfe_rst_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start | (cnt_q != '0);
    if (start) cnt_d = CW'(CYCLES);
    else       cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/irq_reset_frontend.sv
module irq_reset_frontend
  import irqfe_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_SRC-1:0]  ev_in,
  output logic                irq_out,
  output logic                core_rst_out
);
  reg_sel_t           sel;
  logic               wr_gie;
  logic               wr_stat;
  logic               wr_en;
  logic               key_hit;
  logic               clr_regs;
  logic               gie_q;
  logic               gie_d;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] en_d;
  logic               en_upd;

  irqfe_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  always_comb begin
    wr_gie  = bus_wr & (sel == SEL_GIE);
    wr_stat = bus_wr & (sel == SEL_STAT);
    wr_en   = bus_wr & (sel == SEL_EN);
    key_hit = bus_wr & (sel == SEL_SRST) & (bus_wdata == SRST_KEY);
  end

  irqfe_rst_timer #(.CYCLES(RST_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (key_hit),
    .active (core_rst_out)
  );

  assign clr_regs = key_hit | core_rst_out;

  irqfe_status_bits #(.N(NUM_SRC)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_regs),
    .tgl_en (wr_stat),
    .tgl    (bus_wdata[NUM_SRC-1:0]),
    .ev     (ev_in),
    .q      (stat_q)
  );

  // source enable register
  always_comb begin
    en_upd = clr_regs | wr_en;
    en_d   = clr_regs ? '0 : bus_wdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (en_upd) en_q <= en_d;
  end

  // master enable, untouched by the soft reset
  assign gie_d = bus_wdata[GIE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie_q <= 1'b0;
    else if (wr_gie) gie_q <= gie_d;
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_GIE:  bus_rdata[GIE_BIT]     = gie_q;
      SEL_STAT: bus_rdata[NUM_SRC-1:0] = stat_q;
      SEL_EN:   bus_rdata[NUM_SRC-1:0] = en_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_out = gie_q & (|(stat_q & en_q));
endmodule

// File: rtl/irqfe_checker.sv
module irqfe_checker
  import irqfe_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned RST_CYCLES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [NUM_SRC-1:0] ev_in,
  input logic               irq_out,
  input logic               core_rst_out,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic               gie_q
);
  logic        live_q;
  logic        key_w;
  logic        srst_w;
  logic        stat_w;
  int unsigned hi_cnt;

  assign srst_w = bus_wr && (bus_addr == ADDR_W'(OFS_SRST));
  assign key_w  = srst_w && (bus_wdata == SRST_KEY);
  assign stat_w = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      hi_cnt <= 0;
    end else begin
      live_q <= 1'b1;
      if (key_w)             hi_cnt <= 0;
      else if (core_rst_out) hi_cnt <= hi_cnt + 1;
      else                   hi_cnt <= 0;
    end
  end

  AST_EVENT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !core_rst_out && !key_w) |=> ((stat_q & $past(ev_in)) == $past(ev_in))); // R5 R6

  AST_WRITE_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && stat_w && ev_in == '0 && !core_rst_out)
      |=> (stat_q == ($past(stat_q) ^ $past(bus_wdata[NUM_SRC-1:0])))); // R4

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> gie_q); // R7

  AST_RST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $fell(core_rst_out)) |-> (hi_cnt == RST_CYCLES)); // R8

  AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && srst_w && !key_w && !core_rst_out) |=> !core_rst_out); // R9

  AST_RST_HOLDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_out |-> (stat_q == '0 && en_q == '0)); // R10
endmodule

bind irq_reset_frontend irqfe_checker #(
  .ADDR_W     (ADDR_W),
  .RST_CYCLES (RST_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .ev_in        (ev_in),
  .irq_out      (irq_out),
  .core_rst_out (core_rst_out),
  .stat_q       (stat_q),
  .en_q         (en_q),
  .gie_q        (gie_q)
);

// File: tb/test_irq_reset_frontend.sv
`timescale 1ns/1ps
module test_irq_reset_frontend;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  ev_in;
  logic        irq_out;
  logic        core_rst_out;

  int checks;
  int errors;

  // reference model state
  int unsigned m_stat;
  int unsigned m_en;
  int unsigned m_gie;
  int          m_cnt;

  irq_reset_frontend i_irq_reset_frontend (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .ev_in        (ev_in),
    .irq_out      (irq_out),
    .core_rst_out (core_rst_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h1C:   return (m_gie != 0) ? 32'h8000_0000 : 32'h0;
      8'h20:   return 32'(m_stat);
      8'h28:   return 32'(m_en);
      default: return 32'h0;
    endcase
  endfunction

  task automatic compare(input string tag);
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic        exp_rst;
    exp_rd  = m_read(bus_addr);
    exp_irq = (m_gie != 0) && ((m_stat & m_en) != 0);
    exp_rst = (m_cnt != 0);
    checks++;
    if (bus_rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s rdata@%h actual %h expected %h", tag, bus_addr, bus_rdata, exp_rd);
    end
    checks++;
    if (irq_out !== exp_irq) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", tag, irq_out, exp_irq);
    end
    checks++;
    if (core_rst_out !== exp_rst) begin
      errors++;
      $display("FAIL %s core_rst actual %b expected %b", tag, core_rst_out, exp_rst);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; ev_in = e;
    @(posedge clk);
    // model update for this edge
    if (wr && a == 8'h1C) m_gie = d[31];
    if (wr && a == 8'h40 && d == 32'hA) begin
      m_stat = 0; m_en = 0; m_cnt = 16;
    end else if (m_cnt > 0) begin
      m_stat = 0; m_en = 0; m_cnt = m_cnt - 1;
    end else begin
      if (wr && a == 8'h20) m_stat = m_stat ^ int'(d[7:0]);
      m_stat = m_stat | int'(e);
      if (wr && a == 8'h28) m_en = int'(d[7:0]);
    end
    #2;
    compare(tag);
  endtask

  task automatic idle(input int n, input logic [7:0] a, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, a, 32'h0, 8'h00, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    m_stat = 0; m_en = 0; m_gie = 0; m_cnt = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 32'h0; ev_in = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values on every offset
    idle(1, 8'h1C, "R1");
    idle(1, 8'h20, "R1");
    idle(1, 8'h28, "R1");
    idle(1, 8'h40, "R1");

    // R2: master enable stores only bit 31
    step(1'b1, 8'h1C, 32'h7FFF_FFFF, 8'h00, "R2");
    step(1'b1, 8'h1C, 32'hFFFF_FFFF, 8'h00, "R2");
    idle(1, 8'h1C, "R2");

    // R3: enable register keeps the low 8 bits
    step(1'b1, 8'h28, 32'hFFFF_FF5A, 8'h00, "R3");
    idle(1, 8'h28, "R3");

    // R5: event pulses set their own bits; R7 interrupt follows
    step(1'b0, 8'h20, 32'h0, 8'h01, "R5");
    step(1'b0, 8'h20, 32'h0, 8'h08, "R5");
    step(1'b0, 8'h20, 32'h0, 8'h80, "R5");
    idle(1, 8'h20, "R7");

    // R4: writing inverts the bits written with 1
    step(1'b1, 8'h20, 32'hFFFF_FF0F, 8'h00, "R4");
    step(1'b1, 8'h20, 32'h0000_0003, 8'h00, "R4");
    step(1'b1, 8'h20, 32'h0000_0000, 8'h00, "R4");
    idle(1, 8'h20, "R4");

    // R6: event and inversion on the same bits in one cycle
    step(1'b1, 8'h20, 32'h0000_0014, 8'h14, "R6");
    step(1'b1, 8'h20, 32'h0000_0014, 8'h04, "R6");
    idle(1, 8'h20, "R6");

    // R7: interrupt gated by enable and master enable
    step(1'b1, 8'h28, 32'h0000_0000, 8'h00, "R7");
    step(1'b1, 8'h28, 32'h0000_0004, 8'h00, "R7");
    step(1'b1, 8'h1C, 32'h0000_0000, 8'h00, "R7");
    step(1'b1, 8'h1C, 32'h8000_0000, 8'h00, "R7");
    idle(1, 8'h20, "R7");

    // R11: unmapped offsets read 0 and ignore writes
    step(1'b1, 8'h24, 32'hFFFF_FFFF, 8'h00, "R11");
    step(1'b1, 8'h00, 32'hFFFF_FFFF, 8'h00, "R11");
    idle(1, 8'h20, "R11");
    idle(1, 8'h28, "R11");

    // R9: wrong keys have no effect
    step(1'b1, 8'h40, 32'h0000_000B, 8'h00, "R9");
    step(1'b1, 8'h40, 32'h0000_001A, 8'h00, "R9");
    step(1'b1, 8'h40, 32'hA000_0000, 8'h00, "R9");
    idle(2, 8'h20, "R9");

    // R8 R10: keyed reset, events and writes ignored while it runs
    step(1'b1, 8'h40, 32'h0000_000A, 8'h00, "R8");
    step(1'b0, 8'h20, 32'h0, 8'hFF, "R10");
    step(1'b1, 8'h28, 32'h0000_00FF, 8'h00, "R10");
    step(1'b1, 8'h20, 32'h0000_00FF, 8'h00, "R10");
    step(1'b1, 8'h1C, 32'h0000_0000, 8'h00, "R10");
    step(1'b1, 8'h1C, 32'h8000_0000, 8'h00, "R10");
    idle(14, 8'h20, "R8");
    idle(2, 8'h28, "R8");

    // R8: restart while running
    step(1'b1, 8'h40, 32'h0000_000A, 8'h00, "R8");
    idle(6, 8'h20, "R8");
    step(1'b1, 8'h40, 32'h0000_000A, 8'h00, "R8");
    idle(18, 8'h20, "R8");

    // normal operation resumes after the pulse
    step(1'b1, 8'h28, 32'h0000_0020, 8'h00, "R7");
    step(1'b0, 8'h20, 32'h0, 8'h20, "R5");
    idle(2, 8'h1C, "R7");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule